// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block gathers interrupt requests from five sources and offers the most urgent serviceable one to a processor core. The core sees one request line and a three-bit vector index. Three of the sources are asynchronous pins, and each pin is detected in its own way. Pin 0 is sampled as a level. Pin 1 is latched on a rising edge. Pin 2 is latched on an edge whose direction software picks. The other two sources are single-cycle pulses from on-chip units in the same clock domain: a timer overflow and a serial transfer-complete event.

Software writes a six-bit configuration word. It holds one mask bit per source and an edge-select bit for pin 2. A global enable gates the request line. The enable is set by a strobe. When the core takes an interrupt, it returns an acknowledge carrying the vector it served. The acknowledge clears that source's latch and also clears the global enable, so nested requests wait until software re-arms the controller.

Top module: `prio_irq_top`

## Requirements
- R1: After reset the global enable is clear, all five mask bits are set and the edge-select bit is 0. `irqReq` is 0 and `irqVec` is 0, and they stay 0 even if the enable strobe and a timer pulse then arrive while the masks are still set.
- R2: Pin 0 is level-sensitive and active high, with no latch. Once synchronised, it requests vector 0 for as long as it is high, including after an acknowledge followed by re-enabling. The request disappears once the pin returns low.
- R3: A low-to-high change on pin 1 sets its pending latch (vector 1). Holding the pin high causes only one request, and a high-to-low change sets nothing.
- R4: Pin 2 (vector 2) latches a rising edge when edge-select (`cfgData[5]`) is 1 and a falling edge when it is 0. An edge of the other direction is ignored.
- R5: Rewriting edge-select while pin 2's latch is pending leaves the latch pending.
- R6: A one-cycle pulse on `timerOvf` or `serDone` sets the latch of vector 3 or vector 4.
- R7: Mask bit `cfgData[i]` = 1 removes source i from selection, for i from 0 to 4. An edge or pulse that arrives while its source is masked is still latched, and it requests service once the source is unmasked.
- R8: Priority is fixed, from highest to lowest: pin 0, pin 1, pin 2, timer, serial. `irqVec` gives the index (0 to 4) of the highest unmasked pending source while `irqReq` is 1, and is 0 while `irqReq` is 0.
- R9: `irqReq` is 1 only while the global enable is set and at least one unmasked source is pending. A pulse on `enSet` sets the enable.
- R10: A pulse on `ack` clears the latch selected by `ackVec` (pin 0 has none) and clears the global enable. When `ack` and `enSet` arrive in the same cycle, the enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | 3 | Asynchronous external interrupt pins 0..2 |
| timerOvf | input | 1 | Timer overflow pulse, one cycle |
| serDone | input | 1 | Serial transfer-complete pulse, one cycle |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgData | input | 6 | Bits 4:0 are the masks (1 = masked); bit 5 is the pin-2 edge-select |
| enSet | input | 1 | Strobe that sets the global enable |
| ack | input | 1 | Acknowledge strobe from the core |
| ackVec | input | 3 | Vector index being acknowledged |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 3 | Vector index of the selected source |

## Verification
Several properties are checked on every cycle. A request is never raised without the enable or for a masked vector. The vector is idle at 0 whenever there is no request. The request always drops in the cycle after an acknowledge, and an enable strobe without an acknowledge always arms the controller. Other behaviours depend on a history of pin activity and can only be shown by the bench's directed scenarios: detection through the synchroniser, single-shot edges for a held pin, polarity switching, a latch that survives an edge-select rewrite, masked events held back and then released, and the ordering of five concurrently pending sources.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_PIN = 3;
  localparam int VEC_W   = $clog2(NUM_SRC);
  localparam int CFG_W   = NUM_SRC + 1;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrLatch;
    logic [NUM_SRC-1:0] maskBits;
    logic               risingSel;
  } ctlStrobe_t;
endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIN-1:0] extPin,
  input  logic               timerOvf,
  input  logic               serDone,
  input  ctlStrobe_t         ctl,
  output logic               anyElig,
  output logic [VEC_W-1:0]   topVec
);
  logic [NUM_PIN-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PIN-1:0] prevQ;
  logic [NUM_PIN-1:0] cur, rise, fall;
  logic [NUM_SRC-1:0] setEv, latchQ, pend, elig;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else if (g == 0) syncQ[g] <= extPin;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign cur = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else prevQ <= cur;
  end

  assign rise = cur & ~prevQ;
  assign fall = ~cur & prevQ;

  always_comb begin
    setEv    = '0;
    setEv[1] = rise[1];
    setEv[2] = ctl.risingSel ? rise[2] : fall[2];
    setEv[3] = timerOvf;
    setEv[4] = serDone;
  end

  generate
    for (g = 0; g < NUM_SRC; g++) begin : gLatch
      if (g == 0) begin : gLevel
        assign latchQ[g] = 1'b0;
      end else begin : gEdge
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) latchQ[g] <= 1'b0;
          else latchQ[g] <= setEv[g] | (latchQ[g] & ~ctl.clrLatch[g]);
        end
      end
    end
  endgenerate

  always_comb begin
    pend    = latchQ;
    pend[0] = cur[0];
  end

  assign elig    = pend & ~ctl.maskBits;
  assign anyElig = |elig;

  always_comb begin
    topVec = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (elig[i]) topVec = VEC_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             enSet,
  input  logic             ack,
  input  logic [VEC_W-1:0] ackVec,
  input  logic             anyElig,
  input  logic [VEC_W-1:0] topVec,
  output ctlStrobe_t       ctl,
  output logic             globalEn,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVec
);
  logic [NUM_SRC-1:0] maskQ;
  logic               selQ;
  logic               enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      selQ  <= 1'b0;
    end else if (cfgWr) begin
      maskQ <= cfgData[NUM_SRC-1:0];
      selQ  <= cfgData[NUM_SRC];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      enQ <= 1'b0;
    else if (ack)   enQ <= 1'b0;
    else if (enSet) enQ <= 1'b1;
  end

  always_comb begin
    ctl.clrLatch  = '0;
    ctl.maskBits  = maskQ;
    ctl.risingSel = selQ;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ack && ackVec == VEC_W'(i)) ctl.clrLatch[i] = 1'b1;
    end
  end

  assign globalEn = enQ;
  assign irqReq   = enQ & anyElig;
  assign irqVec   = irqReq ? topVec : '0;
endmodule

// File: rtl/prio_irq_top.sv
module prio_irq_top
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] extPin,
  input  logic       timerOvf,
  input  logic       serDone,
  input  logic       cfgWr,
  input  logic [5:0] cfgData,
  input  logic       enSet,
  input  logic       ack,
  input  logic [2:0] ackVec,
  output logic       irqReq,
  output logic [2:0] irqVec
);
  ctlStrobe_t       ctl;
  logic             anyElig;
  logic [VEC_W-1:0] topVec;
  logic             globalEn;
  logic [NUM_SRC-1:0] maskBits;

  assign maskBits = ctl.maskBits;

  prio_irq_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .timerOvf(timerOvf),
    .serDone(serDone), .ctl(ctl), .anyElig(anyElig), .topVec(topVec)
  );

  prio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .enSet(enSet), .ack(ack), .ackVec(ackVec), .anyElig(anyElig),
    .topVec(topVec), .ctl(ctl), .globalEn(globalEn),
    .irqReq(irqReq), .irqVec(irqVec)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enSet,
  input logic       ack,
  input logic       irqReq,
  input logic [2:0] irqVec,
  input logic       globalEn,
  input logic [4:0] maskBits
);
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVec <= 3'd4)); // R8
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVec == 3'd0)); // R8
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> globalEn); // R9
  AST_ENSET_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (enSet && !ack) |=> globalEn); // R9
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (!irqReq && !globalEn)); // R10
  AST_MASKED_NEVER_SEL: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (((maskBits >> irqVec) & 5'd1) == 5'd0)); // R7
endmodule

bind prio_irq_top prio_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .enSet(enSet), .ack(ack), .irqReq(irqReq),
  .irqVec(irqVec), .globalEn(globalEn), .maskBits(maskBits)
);

// File: tb/prio_irq_top_tb.sv
`timescale 1ns/1ps
module prio_irq_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] extPin = '0;
  logic       timerOvf = 1'b0, serDone = 1'b0, cfgWr = 1'b0, enSet = 1'b0, ack = 1'b0;
  logic [5:0] cfgData = '0;
  logic [2:0] ackVec = '0;
  logic       irqReq;
  logic [2:0] irqVec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit          expReqQ[$];
  logic [2:0]  expVecQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  prio_irq_top u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .timerOvf(timerOvf),
    .serDone(serDone), .cfgWr(cfgWr), .cfgData(cfgData), .enSet(enSet),
    .ack(ack), .ackVec(ackVec), .irqReq(irqReq), .irqVec(irqVec)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (expReqQ.size() > 0) begin
      bit r; logic [2:0] v; string t;
      r = expReqQ.pop_front(); v = expVecQ.pop_front(); t = tagQ.pop_front();
      total++;
      if (irqReq !== r || irqVec !== v) begin
        bad++;
        $display("FAIL %s: irqReq/irqVec got %0b/%0d expected %0b/%0d", t, irqReq, irqVec, r, v);
      end
    end
  end

  task automatic expectOut(input bit r, input logic [2:0] v, input string t);
    @(posedge clk); #1;
    expReqQ.push_back(r); expVecQ.push_back(v); tagQ.push_back(t);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [5:0] d);
    @(negedge clk); cfgWr = 1'b1; cfgData = d;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic armEn();
    @(negedge clk); enSet = 1'b1;
    @(negedge clk); enSet = 1'b0;
  endtask

  task automatic doAck(input logic [2:0] v);
    @(negedge clk); ack = 1'b1; ackVec = v;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic ackArm(input logic [2:0] v);
    doAck(v); armEn();
  endtask

  task automatic pulseTimer();
    @(negedge clk); timerOvf = 1'b1;
    @(negedge clk); timerOvf = 1'b0;
  endtask

  task automatic pulseSer();
    @(negedge clk); serDone = 1'b1;
    @(negedge clk); serDone = 1'b0;
  endtask

  task automatic setPin(input int idx, input logic val);
    @(negedge clk); extPin[idx] = val;
    settle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    expectOut(0, 3'd0, "R1 reset");
    armEn(); pulseTimer();
    expectOut(0, 3'd0, "R1 all masked after reset");
    writeCfg(6'b100000);
    expectOut(1, 3'd3, "R7 latched while masked");
    ackArm(3'd3);
    expectOut(0, 3'd0, "R10 latch cleared");

    // R6 pulses and R8 priority between them
    pulseTimer(); pulseSer();
    expectOut(1, 3'd3, "R6 timer above serial");
    doAck(3'd3);
    expectOut(0, 3'd0, "R9 enable cleared by ack");
    armEn();
    expectOut(1, 3'd4, "R6 serial latched");
    ackArm(3'd4);
    expectOut(0, 3'd0, "R10 serial cleared");
    pulseTimer();
    doAck(3'd0);
    @(negedge clk); ack = 1'b1; ackVec = 3'd0; enSet = 1'b1;
    @(negedge clk); ack = 1'b0; enSet = 1'b0;
    expectOut(0, 3'd0, "R10 ack beats enSet");
    armEn();
    expectOut(1, 3'd3, "R9 enSet arms");
    ackArm(3'd3);

    // R2 level pin
    setPin(0, 1'b1);
    expectOut(1, 3'd0, "R2 level seen");
    doAck(3'd0);
    expectOut(0, 3'd0, "R10 ack vector 0");
    armEn();
    expectOut(1, 3'd0, "R2 level persists");
    setPin(0, 1'b0);
    expectOut(0, 3'd0, "R2 level gone");

    // R3 rising edge pin
    setPin(1, 1'b1);
    expectOut(1, 3'd1, "R3 rising latched");
    ackArm(3'd1); settle(2);
    expectOut(0, 3'd0, "R3 held high single shot");
    setPin(1, 1'b0);
    expectOut(0, 3'd0, "R3 falling ignored");

    // R4 programmable polarity
    setPin(2, 1'b1);
    expectOut(1, 3'd2, "R4 rising with select 1");
    ackArm(3'd2);
    writeCfg(6'b000000);
    setPin(2, 1'b0);
    expectOut(1, 3'd2, "R4 falling with select 0");
    ackArm(3'd2);
    setPin(2, 1'b1);
    expectOut(0, 3'd0, "R4 rising ignored with select 0");

    // R5 select rewrite keeps pending
    setPin(2, 1'b0);
    writeCfg(6'b100000);
    expectOut(1, 3'd2, "R5 pending survives select change");
    ackArm(3'd2);
    expectOut(0, 3'd0, "R10 pin2 cleared");

    // R7 masking
    writeCfg(6'b101000);
    pulseTimer();
    expectOut(0, 3'd0, "R7 timer masked");
    writeCfg(6'b100000);
    expectOut(1, 3'd3, "R7 unmasked releases");
    ackArm(3'd3);

    // R8 full priority order
    writeCfg(6'b011111);
    setPin(2, 1'b1); setPin(2, 1'b0);
    setPin(1, 1'b1);
    pulseTimer(); pulseSer();
    expectOut(0, 3'd0, "R7 all masked");
    writeCfg(6'b000000);
    expectOut(1, 3'd1, "R8 pin1 first");
    setPin(0, 1'b1);
    expectOut(1, 3'd0, "R8 pin0 highest");
    ackArm(3'd0);
    expectOut(1, 3'd0, "R8 pin0 still high");
    setPin(0, 1'b0);
    expectOut(1, 3'd1, "R8 back to pin1");
    ackArm(3'd1);
    expectOut(1, 3'd2, "R8 pin2 next");
    ackArm(3'd2);
    expectOut(1, 3'd3, "R8 timer next");
    ackArm(3'd3);
    expectOut(1, 3'd4, "R8 serial last");
    ackArm(3'd4);
    expectOut(0, 3'd0, "R8 all served");

    settle(3);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule